// File: doc/BRIEF.md
# Inter-Processor Interrupt Send Dispatcher

The dispatcher takes 64-bit send commands, one at a time, and turns each into an access on a target-core register port. The offset and width of the incoming command write pick its kind. A narrow write at the interrupt offset raises one vector in the target core. A wide write at the mailbox offset stores a word into one of the target's mailbox slots. A wide write at the direct offset stores a word at any 16-bit register address in the target.

Mailbox and direct sends carry a four-bit byte-keep field. If any keep bit is set, the dispatcher first reads the current target word. It then merges the old kept bytes with the new payload and writes the result back. While such a sequence is running, the block shows busy and takes no new command.

Every target access is a request with a valid/ready handshake. A read returns its data on a separate valid strobe.

Top module: `ipi_send_dispatch`

## Requirements
- R1: Every target access carries the target core identifier taken from command bits [25:16].
- R2: A 32-bit command (cmd_wide_i=0) at offset 0x040 produces exactly one write, with no read, to target address 0x1008. The write data is a 32-bit word with only bit cmd[4:0] set, and tgt_irq_o is high during that write. Command bits [30:27] have no effect on this kind.
- R3: A 64-bit command (cmd_wide_i=1) at offset 0x048 targets address 0x1020 + (cmd[15:0] & 0x001C).
- R4: A 64-bit command at offset 0x158 targets address cmd[15:0].
- R5: For mailbox and direct sends with keep field cmd[30:27] nonzero, a read of the same core and address comes first. The following write carries (old & M) | (cmd[63:32] & ~M). Byte i of M (bits 8i+7..8i) is all ones when cmd[27+i] is set.
- R6: For mailbox and direct sends with a zero keep field, no read is issued, and the write carries cmd[63:32] unchanged.
- R7: Commands at any other offset, and commands of the wrong width at a known offset, produce no target access and do not make the block busy.
- R8: cmd_ready_o is high only when no command is in progress, and busy_o is its inverse. A command presented while busy is not taken and produces no later access.
- R9: A target request holds its valid, direction, core, address and data until tgt_ready_i is seen. Read data is taken only in a cycle with rd_valid_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command write strobe |
| cmd_wide_i | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| cmd_ofs_i | input | 12 | Offset of the command write |
| cmd_data_i | input | 64 | Command word |
| cmd_ready_o | output | 1 | Dispatcher idle, command taken when valid |
| busy_o | output | 1 | Command sequence in progress |
| tgt_valid_o | output | 1 | Target request valid |
| tgt_ready_i | input | 1 | Target accepts request |
| tgt_write_o | output | 1 | 1 = write, 0 = read |
| tgt_core_o | output | 10 | Target core identifier |
| tgt_addr_o | output | 16 | Target register address |
| tgt_wdata_o | output | 32 | Write data |
| tgt_irq_o | output | 1 | Raise the target interrupt line with this write |
| rd_valid_i | input | 1 | Read data returned |
| rd_data_i | input | 32 | Returned read data |

## Verification
The assertions assume that the target answers each read with exactly one rd_valid_i pulse, and only after the read request has been accepted. They also assume that tgt_ready_i matters only while a request is valid. The stimulus acts as that target. It raises ready after a random delay, returns one deterministic old word per read, and puts random garbage on rd_data_i with rd_valid_i low while the read is pending. Commands mix the three valid kinds with stray offsets, wrong widths and intruding commands sent while busy.

// File: rtl/ipi_disp_pkg.sv
package ipi_disp_pkg;
  localparam int CMD_W   = 64;
  localparam int DATA_W  = 32;
  localparam int CORE_W  = 10;
  localparam int ADDR_W  = 16;
  localparam int OFS_W   = 12;
  localparam int VEC_W   = 5;
  localparam int NBYTE   = DATA_W / 8;
  localparam int CORE_LSB = 16;
  localparam int KEEP_LSB = 27;

  typedef enum logic [1:0] {
    KIND_NONE,
    KIND_IRQ,
    KIND_MAIL,
    KIND_ANY
  } kind_e;

  typedef struct packed {
    kind_e               kind;
    logic [CORE_W-1:0]   core;
    logic [ADDR_W-1:0]   addr;
    logic [DATA_W-1:0]   data;
    logic [NBYTE-1:0]    keep;
  } op_t;
endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
  import ipi_disp_pkg::*;
#(
  parameter logic [OFS_W-1:0]  IRQ_OFS   = 12'h040,
  parameter logic [OFS_W-1:0]  MAIL_OFS  = 12'h048,
  parameter logic [OFS_W-1:0]  ANY_OFS   = 12'h158,
  parameter logic [ADDR_W-1:0] SET_ADDR  = 16'h1008,
  parameter logic [ADDR_W-1:0] MBOX_BASE = 16'h1020,
  parameter logic [ADDR_W-1:0] MBOX_MASK = 16'h001C
) (
  input  logic [OFS_W-1:0] ofs_i,
  input  logic             wide_i,
  input  logic [CMD_W-1:0] cmd_i,
  output op_t              op_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] payload;
  logic [NBYTE-1:0]  keep_raw;
  logic [ADDR_W-1:0] low_addr;

  assign payload  = cmd_i[CMD_W-1 -: DATA_W];
  assign keep_raw = cmd_i[KEEP_LSB +: NBYTE];
  assign low_addr = cmd_i[ADDR_W-1:0];

  always_comb begin
    op_o      = '0;
    op_o.core = cmd_i[CORE_LSB +: CORE_W];
    if (!wide_i && ofs_i == IRQ_OFS) begin
      op_o.kind = KIND_IRQ;
      op_o.addr = SET_ADDR;
      op_o.data = ONE << cmd_i[VEC_W-1:0];
      op_o.keep = '0;
    end else if (wide_i && ofs_i == MAIL_OFS) begin
      op_o.kind = KIND_MAIL;
      op_o.addr = MBOX_BASE + (low_addr & MBOX_MASK);
      op_o.data = payload;
      op_o.keep = keep_raw;
    end else if (wide_i && ofs_i == ANY_OFS) begin
      op_o.kind = KIND_ANY;
      op_o.addr = low_addr;
      op_o.data = payload;
      op_o.keep = keep_raw;
    end
  end
endmodule

// File: rtl/ipi_byte_mask.sv
module ipi_byte_mask
  import ipi_disp_pkg::*;
(
  input  logic [NBYTE-1:0]  keep_i,
  output logic [DATA_W-1:0] mask_o
);
  for (genvar i = 0; i < NBYTE; i++) begin : g_byte
    assign mask_o[i*8 +: 8] = {8{keep_i[i]}};
  end
endmodule

// File: rtl/ipi_rmw_seq.sv
module ipi_rmw_seq
  import ipi_disp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  op_t               op_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [NBYTE-1:0]  keep_o,
  output logic              cmd_ready_o,
  output logic              busy_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic              req_write_o,
  output logic [CORE_W-1:0] req_core_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [DATA_W-1:0] req_wdata_o,
  output logic              req_irq_o,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i
);
  typedef enum logic [1:0] {S_IDLE, S_RD_REQ, S_RD_WAIT, S_WR} state_e;

  state_e state_q;
  op_t    op_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      op_q    <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (cmd_valid_i && op_i.kind != KIND_NONE) begin
          op_q    <= op_i;
          state_q <= (op_i.keep != '0) ? S_RD_REQ : S_WR;
        end
        S_RD_REQ: if (req_ready_i) state_q <= S_RD_WAIT;
        S_RD_WAIT: if (rd_valid_i) begin
          // keep old bytes under mask, new payload elsewhere
          op_q.data <= (rd_data_i & mask_i) | (op_q.data & ~mask_i);
          state_q   <= S_WR;
        end
        S_WR: if (req_ready_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign keep_o      = op_q.keep;
  assign cmd_ready_o = (state_q == S_IDLE);
  assign busy_o      = (state_q != S_IDLE);
  assign req_valid_o = (state_q == S_RD_REQ) || (state_q == S_WR);
  assign req_write_o = (state_q == S_WR);
  assign req_core_o  = op_q.core;
  assign req_addr_o  = op_q.addr;
  assign req_wdata_o = op_q.data;
  assign req_irq_o   = (state_q == S_WR) && (op_q.kind == KIND_IRQ);

  assert_req_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_write_o) &&
      $stable(req_core_o) && $stable(req_addr_o) && $stable(req_wdata_o));

  assert_read_needs_keep_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_write_o |-> keep_o != '0);

  assert_irq_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_irq_o |-> req_valid_o && req_write_o && $countones(req_wdata_o) == 1);

  assert_busy_locks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(req_core_o) && $stable(req_addr_o));

  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> !req_valid_o);
endmodule

// File: rtl/ipi_send_dispatch.sv
module ipi_send_dispatch
  import ipi_disp_pkg::*;
#(
  parameter logic [OFS_W-1:0]  IRQ_OFS   = 12'h040,
  parameter logic [OFS_W-1:0]  MAIL_OFS  = 12'h048,
  parameter logic [OFS_W-1:0]  ANY_OFS   = 12'h158,
  parameter logic [ADDR_W-1:0] SET_ADDR  = 16'h1008,
  parameter logic [ADDR_W-1:0] MBOX_BASE = 16'h1020
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_wide_i,
  input  logic [OFS_W-1:0]  cmd_ofs_i,
  input  logic [CMD_W-1:0]  cmd_data_i,
  output logic              cmd_ready_o,
  output logic              busy_o,
  output logic              tgt_valid_o,
  input  logic              tgt_ready_i,
  output logic              tgt_write_o,
  output logic [CORE_W-1:0] tgt_core_o,
  output logic [ADDR_W-1:0] tgt_addr_o,
  output logic [DATA_W-1:0] tgt_wdata_o,
  output logic              tgt_irq_o,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i
);
  op_t               dec_op;
  logic [NBYTE-1:0]  keep;
  logic [DATA_W-1:0] mask;

  ipi_cmd_decode #(
    .IRQ_OFS  (IRQ_OFS),
    .MAIL_OFS (MAIL_OFS),
    .ANY_OFS  (ANY_OFS),
    .SET_ADDR (SET_ADDR),
    .MBOX_BASE(MBOX_BASE),
    .MBOX_MASK(16'h001C)
  ) u_decode (
    .ofs_i (cmd_ofs_i),
    .wide_i(cmd_wide_i),
    .cmd_i (cmd_data_i),
    .op_o  (dec_op)
  );

  ipi_byte_mask u_mask (
    .keep_i(keep),
    .mask_o(mask)
  );

  ipi_rmw_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid_i),
    .op_i       (dec_op),
    .mask_i     (mask),
    .keep_o     (keep),
    .cmd_ready_o(cmd_ready_o),
    .busy_o     (busy_o),
    .req_valid_o(tgt_valid_o),
    .req_ready_i(tgt_ready_i),
    .req_write_o(tgt_write_o),
    .req_core_o (tgt_core_o),
    .req_addr_o (tgt_addr_o),
    .req_wdata_o(tgt_wdata_o),
    .req_irq_o  (tgt_irq_o),
    .rd_valid_i (rd_valid_i),
    .rd_data_i  (rd_data_i)
  );

  assert_irq_set_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_irq_o |-> tgt_addr_o == SET_ADDR);
endmodule

// File: tb/ipi_send_dispatch_bench.sv
module ipi_send_dispatch_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 150000;
  localparam logic [11:0] O_IRQ = 12'h040, O_MAIL = 12'h048, O_ANY = 12'h158;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_wide = 1'b0;
  logic [11:0] cmd_ofs = '0;
  logic [63:0] cmd_data = '0;
  logic        cmd_ready, busy, tgt_valid, tgt_write, tgt_irq;
  logic        tgt_ready = 1'b0, rd_valid = 1'b0;
  logic [9:0]  tgt_core;
  logic [15:0] tgt_addr;
  logic [31:0] tgt_wdata, rd_data = '0;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_send_dispatch u_ipi_send_dispatch (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_wide_i(cmd_wide), .cmd_ofs_i(cmd_ofs),
    .cmd_data_i(cmd_data), .cmd_ready_o(cmd_ready), .busy_o(busy),
    .tgt_valid_o(tgt_valid), .tgt_ready_i(tgt_ready), .tgt_write_o(tgt_write),
    .tgt_core_o(tgt_core), .tgt_addr_o(tgt_addr), .tgt_wdata_o(tgt_wdata),
    .tgt_irq_o(tgt_irq), .rd_valid_i(rd_valid), .rd_data_i(rd_data)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] old_word(input logic [9:0] core, input logic [15:0] addr);
    return {addr ^ 16'h5A3C, 6'b010110, core};
  endfunction

  function automatic int kind_of(input logic [11:0] ofs, input logic wide);
    if (!wide && ofs == O_IRQ) return 1;
    if (wide && ofs == O_MAIL) return 2;
    if (wide && ofs == O_ANY) return 3;
    return 0;
  endfunction

  function automatic logic [31:0] keep_mask(input logic [3:0] k);
    logic [31:0] m = '0;
    for (int i = 0; i < 4; i++) if (k[i]) m[i*8 +: 8] = 8'hFF;
    return m;
  endfunction

  task automatic handshake();
    repeat ($urandom % 3) @(negedge clk);
    tgt_ready = 1'b1;
    @(negedge clk);
    tgt_ready = 1'b0;
  endtask

  task automatic run_cmd(input logic [11:0] ofs, input logic wide,
                         input logic [63:0] d, input bit intrude);
    int          k = kind_of(ofs, wide);
    logic [9:0]  e_core = d[25:16];
    logic [15:0] e_addr;
    logic [3:0]  keep;
    logic [31:0] e_data, old, m;
    string       tag;

    @(negedge clk);
    chk(cmd_ready && !busy, "R8 idle before command", {cmd_ready, busy}, 2'b10);
    cmd_valid = 1'b1; cmd_wide = wide; cmd_ofs = ofs; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (k == 0) begin
      for (int i = 0; i < 5; i++) begin
        chk(!tgt_valid && !busy, "R7 ignored command", {tgt_valid, busy}, 0);
        @(negedge clk);
      end
      return;
    end
    tag    = (k == 1) ? "R2" : (k == 2) ? "R3" : "R4";
    e_addr = (k == 1) ? 16'h1008 : (k == 2) ? (16'h1020 + (d[15:0] & 16'h001C)) : d[15:0];
    keep   = (k == 1) ? 4'h0 : d[30:27];
    e_data = (k == 1) ? (32'd1 << d[4:0]) : d[63:32];
    chk(busy && !cmd_ready, "R8 busy while working", {busy, cmd_ready}, 2'b10);
    if (intrude) begin
      cmd_valid = 1'b1; cmd_wide = 1'b1; cmd_ofs = O_ANY;
      cmd_data = 64'h1234_5678_0001_0BEE;
    end
    if (keep != 0) begin
      repeat ($urandom % 3) @(negedge clk);
      chk(tgt_valid && !tgt_write, "R5 read first", {tgt_valid, tgt_write}, 2'b10);
      chk(tgt_core == e_core, "R1 read core", tgt_core, e_core);
      chk(tgt_addr == e_addr, {tag, " R5 read addr"}, tgt_addr, e_addr);
      tgt_ready = 1'b1;
      @(negedge clk);
      tgt_ready = 1'b0;
      for (int i = 0; i < int'($urandom % 3) + 1; i++) begin
        rd_data = $urandom;
        @(negedge clk);
      end
      chk(!tgt_valid, "R9 no request while awaiting data", tgt_valid, 0);
      old = old_word(e_core, e_addr);
      rd_valid = 1'b1; rd_data = old;
      @(negedge clk);
      rd_valid = 1'b0; rd_data = $urandom;
      m = keep_mask(keep);
      e_data = (old & m) | (e_data & ~m);
    end else begin
      repeat ($urandom % 3) @(negedge clk);
    end
    chk(tgt_valid && tgt_write, (keep != 0) ? "R5 write after read" : "R6 direct write",
        {tgt_valid, tgt_write}, 2'b11);
    chk(tgt_core == e_core, "R1 write core", tgt_core, e_core);
    chk(tgt_addr == e_addr, {tag, " write addr"}, tgt_addr, e_addr);
    chk(tgt_wdata == e_data, (keep != 0) ? "R5 merged data" : (k == 1) ? "R2 vector word" : "R6 full data",
        tgt_wdata, e_data);
    chk(tgt_irq == (k == 1), "R2 irq flag", tgt_irq, (k == 1));
    if (intrude) chk(!cmd_ready, "R8 not ready while busy", cmd_ready, 0);
    handshake();
    cmd_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk(!tgt_valid && !busy, "R8 no access after command", {tgt_valid, busy}, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!tgt_valid && cmd_ready == 1'b0 || !tgt_valid, "R8 reset quiet", tgt_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready && !busy && !tgt_valid, "R8 reset state", {cmd_ready, busy, tgt_valid}, 3'b100);
    // directed corners
    run_cmd(O_IRQ, 1'b0, 64'h0000_0000_0123_0000, 1'b0);
    run_cmd(O_IRQ, 1'b0, 64'hFFFF_FFFF_7BFF_001F, 1'b0);
    run_cmd(O_MAIL, 1'b1, 64'hCAFE_BABE_0005_003C, 1'b0);
    run_cmd(O_MAIL, 1'b1, 64'hCAFE_BABE_7805_0014, 1'b0);
    for (int i = 0; i < 4; i++)
      run_cmd(O_ANY, 1'b1, {32'h1122_3344, 1'b0, 4'(1 << i), 11'h3FF, 16'h1100}, 1'b0);
    run_cmd(O_ANY, 1'b1, 64'hDEAD_BEEF_2802_ABCD, 1'b1);
    run_cmd(O_MAIL, 1'b1, 64'h0BAD_F00D_0001_0004, 1'b1);
    run_cmd(O_IRQ, 1'b1, 64'h0000_0000_0001_0003, 1'b0);
    run_cmd(O_MAIL, 1'b0, 64'h1111_1111_7801_0000, 1'b0);
    run_cmd(12'h044, 1'b1, 64'h1111_1111_0001_0000, 1'b0);
    // random mix
    for (int n = 0; n < 200; n++) begin
      logic [11:0] o;
      logic [63:0] d;
      int sel = $urandom % 5;
      o = (sel == 0) ? O_IRQ : (sel == 1) ? O_MAIL : (sel == 2) ? O_ANY :
          (sel == 3) ? O_ANY : 12'($urandom);
      d = {$urandom, $urandom};
      if ($urandom % 3 == 0) d[30:27] = 4'h0;
      run_cmd(o, (sel == 0) ? ($urandom % 8 == 0) : ($urandom % 8 != 0), d, ($urandom % 4 == 0));
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule